// File: doc/BRIEF.md
# Supply Power-On Reset and Dropout Supervisor

This block turns the digital outputs of two supply comparators into the control signals that keep a card interface safe during power-up and power-down. One comparator flag reports that the supply is above the rising threshold (base level plus hysteresis). The other reports that it is still above the lower falling threshold. From these flags the block produces an internal active-high reset, which is stretched by a timed pulse after the supply comes up. It also produces a single-cycle deactivation request for the card sequencer when the supply collapses during a session, and an active-low status line for the host.

All inputs are taken through a parameterised synchronizer into the timing-clock domain. The stretch length is a parameter counted in timing-clock cycles, for example the cycle count of 8 ms at the chosen clock rate. A flag reporting that an external threshold divider is fitted lengthens the pulse by a left shift (doubling by default). The flag is captured once, when a valid rise is first seen. The status line stays low after power-up until the host first raises its power command while the block is active. It drops again as soon as a dropout is seen.

Top module: `psv_supervisor`

## Requirements
- R1: While `arst_ni` is low and directly after it is released, `por_o` is 1, `deact_req_o` is 0 and `stat_n_o` is 0.
- R2: As long as the synchronized rising flag has not been seen high since the last reset or dropout, `por_o` stays 1 whatever the levels on `pwr_cmd_i` and `ext_div_i`.
- R3: With `ext_div_i` low, once `rise_ok_i` goes high and stays high, `por_o` stays 1 for exactly SYNC_STAGES + BASE_CYCLES more clock cycles (counted at the first clock edge that samples the new level) and then goes to 0.
- R4: If `ext_div_i` is high in the cycle in which the rise is first seen, the stretch lasts BASE_CYCLES << EXT_SHIFT cycles. A later change of `ext_div_i` during that stretch has no effect on its length.
- R5: If `rise_ok_i` drops during the stretch, `por_o` stays 1 and the count restarts from zero on the next rise, so the full length is counted again from that rise.
- R6: When `fall_ok_i` goes low while the block is active (`por_o` is 0), `deact_req_o` is 1 for exactly one cycle, after SYNC_STAGES + 1 clock edges. During that cycle `por_o` is 0, and `por_o` returns to 1 in the cycle after it.
- R7: `stat_n_o` goes from 0 to 1 only in the cycle after the synchronized `pwr_cmd_i` is seen high while the block is active. A command given while `por_o` is 1 does not raise it.
- R8: `stat_n_o` is 0 in the same cycle as the `deact_req_o` pulse, and it stays 0 through the next power-up until the command is again seen high while the block is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running timing clock |
| arst_ni | input | 1 | Asynchronous active-low initialisation |
| rise_ok_i | input | 1 | Supply above rising threshold (comparator flag) |
| fall_ok_i | input | 1 | Supply above falling threshold (comparator flag) |
| ext_div_i | input | 1 | External threshold divider detected |
| pwr_cmd_i | input | 1 | Host power command, active high |
| por_o | output | 1 | Internal reset, active high |
| deact_req_o | output | 1 | One-cycle deactivation request to the card sequencer |
| stat_n_o | output | 1 | Active-low status/interrupt line to the host |

## Verification
The assertions assume that the two comparator flags are consistent with the hysteresis: whenever the supply is above the rising threshold it is also above the falling one, so the rising flag is never high while the falling flag is low. The bench only ever moves the falling flag low together with the rising flag, or after it, and raises it before or together with the rising flag. Stimulus changes on the falling clock edge and holds each level for several cycles, so every level passes the synchronizer cleanly.

// File: rtl/psv_pkg.sv
package psv_pkg;

   typedef enum logic [1:0] {
      ST_POWER_LOW = 2'd0,
      ST_STRETCH   = 2'd1,
      ST_ACTIVE    = 2'd2,
      ST_DROPOUT   = 2'd3
   } psv_state_e;

   localparam int unsigned FLAG_RISE = 0;
   localparam int unsigned FLAG_FALL = 1;
   localparam int unsigned FLAG_EXT  = 2;
   localparam int unsigned FLAG_CMD  = 3;
   localparam int unsigned FLAG_N    = 4;

endpackage

// File: rtl/psv_sync.sv
module psv_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("psv_sync: WIDTH must be at least 1");
      end

      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) begin
               for (int i = 0; i < int'(STAGES); i++) begin
                  stage_q[i] <= '0;
               end
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < int'(STAGES); i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end

         assign q_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/psv_stretch_timer.sv
module psv_stretch_timer #(
   parameter int unsigned BASE_CYCLES = 20,
   parameter int unsigned EXT_SHIFT   = 1
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic load_i,
   input  logic ext_sel_i,
   input  logic run_i,
   output logic done_o
);

   localparam int unsigned LEN_BASE = BASE_CYCLES;
   localparam int unsigned LEN_EXT  = BASE_CYCLES << EXT_SHIFT;
   localparam int unsigned CNT_W    = $clog2(LEN_EXT + 1);
   localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(LEN_BASE - 1);
   localparam logic [CNT_W-1:0] LAST_EXT  = CNT_W'(LEN_EXT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             ext_q;
   logic [CNT_W-1:0] last_cnt;

   generate
      if (BASE_CYCLES < 1) begin : g_bad_base
         $error("psv_stretch_timer: BASE_CYCLES must be at least 1");
      end
      if (EXT_SHIFT > 4) begin : g_bad_shift
         $error("psv_stretch_timer: EXT_SHIFT must be 0 to 4");
      end
   endgenerate

   assign last_cnt = ext_q ? LAST_EXT : LAST_BASE;
   assign done_o   = run_i && (cnt_q == last_cnt);

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         cnt_q <= '0;
         ext_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= '0;
         ext_q <= ext_sel_i;
      end else if (run_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/psv_ctrl.sv
module psv_ctrl
   import psv_pkg::*;
(
   input  logic       clk_i,
   input  logic       arst_ni,
   input  logic       rise_s_i,
   input  logic       fall_s_i,
   input  logic       timer_done_i,
   output logic       timer_load_o,
   output logic       timer_run_o,
   output logic       drop_o,
   output psv_state_e state_o
);

   psv_state_e state_q, state_d;

   always_comb begin
      state_d      = state_q;
      timer_load_o = 1'b0;
      timer_run_o  = 1'b0;
      drop_o       = 1'b0;
      unique case (state_q)
         ST_POWER_LOW: begin
            if (rise_s_i) begin
               state_d      = ST_STRETCH;
               timer_load_o = 1'b1;
            end
         end
         ST_STRETCH: begin
            if (!rise_s_i) begin
               state_d = ST_POWER_LOW;
            end else begin
               timer_run_o = 1'b1;
               if (timer_done_i) begin
                  state_d = ST_ACTIVE;
               end
            end
         end
         ST_ACTIVE: begin
            if (!fall_s_i) begin
               state_d = ST_DROPOUT;
               drop_o  = 1'b1;
            end
         end
         ST_DROPOUT: begin
            state_d = ST_POWER_LOW;
         end
         default: state_d = ST_POWER_LOW;
      endcase
   end

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         state_q <= ST_POWER_LOW;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/psv_status.sv
module psv_status (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic active_i,
   input  logic cmd_s_i,
   input  logic drop_i,
   output logic stat_n_o
);

   logic stat_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         stat_q <= 1'b0;
      end else if (drop_i) begin
         stat_q <= 1'b0;
      end else if (active_i && cmd_s_i) begin
         stat_q <= 1'b1;
      end
   end

   assign stat_n_o = stat_q;

endmodule

// File: rtl/psv_supervisor.sv
module psv_supervisor
   import psv_pkg::*;
#(
   parameter int unsigned BASE_CYCLES = 400000,
   parameter int unsigned EXT_SHIFT   = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic rise_ok_i,
   input  logic fall_ok_i,
   input  logic ext_div_i,
   input  logic pwr_cmd_i,
   output logic por_o,
   output logic deact_req_o,
   output logic stat_n_o
);

   generate
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("psv_supervisor: SYNC_STAGES must be 0 to 8");
      end
   endgenerate

   logic [FLAG_N-1:0] flags_raw, flags_s;
   logic rise_s, fall_s, ext_s, pwr_s;
   logic timer_load, timer_run, timer_done, drop;
   psv_state_e state;

   always_comb begin
      flags_raw            = '0;
      flags_raw[FLAG_RISE] = rise_ok_i;
      flags_raw[FLAG_FALL] = fall_ok_i;
      flags_raw[FLAG_EXT]  = ext_div_i;
      flags_raw[FLAG_CMD]  = pwr_cmd_i;
   end

   psv_sync #(
      .WIDTH  (FLAG_N),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .d_i     (flags_raw),
      .q_o     (flags_s)
   );

   assign rise_s = flags_s[FLAG_RISE];
   assign fall_s = flags_s[FLAG_FALL];
   assign ext_s  = flags_s[FLAG_EXT];
   assign pwr_s  = flags_s[FLAG_CMD];

   psv_ctrl u_ctrl (
      .clk_i        (clk_i),
      .arst_ni      (arst_ni),
      .rise_s_i     (rise_s),
      .fall_s_i     (fall_s),
      .timer_done_i (timer_done),
      .timer_load_o (timer_load),
      .timer_run_o  (timer_run),
      .drop_o       (drop),
      .state_o      (state)
   );

   psv_stretch_timer #(
      .BASE_CYCLES (BASE_CYCLES),
      .EXT_SHIFT   (EXT_SHIFT)
   ) u_timer (
      .clk_i     (clk_i),
      .arst_ni   (arst_ni),
      .load_i    (timer_load),
      .ext_sel_i (ext_s),
      .run_i     (timer_run),
      .done_o    (timer_done)
   );

   psv_status u_status (
      .clk_i    (clk_i),
      .arst_ni  (arst_ni),
      .active_i (state == ST_ACTIVE),
      .cmd_s_i  (pwr_s),
      .drop_i   (drop),
      .stat_n_o (stat_n_o)
   );

   assign por_o       = (state == ST_POWER_LOW) || (state == ST_STRETCH);
   assign deact_req_o = (state == ST_DROPOUT);

endmodule

// File: rtl/psv_checker.sv
module psv_checker #(
   parameter int unsigned BASE_CYCLES = 400000
) (
   input logic clk_i,
   input logic arst_ni,
   input logic rise_s,
   input logic fall_s,
   input logic pwr_s,
   input logic por_o,
   input logic deact_req_o,
   input logic stat_n_o
);

   localparam int unsigned RUN_W = $clog2(BASE_CYCLES + 2);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BASE_CYCLES + 1);

   logic [RUN_W-1:0] rise_run_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         rise_run_q <= '0;
      end else if (por_o && rise_s) begin
         if (rise_run_q != RUN_MAX) rise_run_q <= rise_run_q + 1'b1;
      end else begin
         rise_run_q <= '0;
      end
   end

   AST_RESET_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (por_o && !rise_s) |=> por_o); // R2

   AST_MIN_STRETCH: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $fell(por_o) |-> (rise_run_q >= RUN_W'(BASE_CYCLES))); // R3

   AST_ACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (!por_o && !deact_req_o && fall_s) |=> (!por_o && !deact_req_o)); // R6

   AST_DEACT_SINGLE: assert property (@(posedge clk_i) disable iff (!arst_ni)
      deact_req_o |=> (!deact_req_o && por_o)); // R6

   AST_DEACT_CAUSE: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $rose(deact_req_o) |-> ($past(!por_o) && $past(!fall_s))); // R6

   AST_DEACT_EXCL: assert property (@(posedge clk_i) disable iff (!arst_ni)
      deact_req_o |-> !por_o); // R6

   AST_STAT_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $rose(stat_n_o) |-> ($past(pwr_s) && $past(!por_o) && $past(!deact_req_o))); // R7

   AST_STAT_LOW_ON_DROP: assert property (@(posedge clk_i) disable iff (!arst_ni)
      deact_req_o |-> !stat_n_o); // R8

   AST_STAT_LOW_IN_RESET: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (por_o && !stat_n_o) |=> !stat_n_o); // R8

endmodule

bind psv_supervisor psv_checker #(
   .BASE_CYCLES (BASE_CYCLES)
) u_chk (
   .clk_i       (clk_i),
   .arst_ni     (arst_ni),
   .rise_s      (rise_s),
   .fall_s      (fall_s),
   .pwr_s       (pwr_s),
   .por_o       (por_o),
   .deact_req_o (deact_req_o),
   .stat_n_o    (stat_n_o)
);

// File: tb/tb_psv_supervisor.sv
module tb_psv_supervisor;

   localparam int BASE = 20;
   localparam int SHIFT = 1;
   localparam int SYNC = 2;

   logic clk_i = 1'b0;
   logic arst_ni = 1'b0;
   logic rise_ok_i = 1'b0;
   logic fall_ok_i = 1'b0;
   logic ext_div_i = 1'b0;
   logic pwr_cmd_i = 1'b0;
   logic por_o, deact_req_o, stat_n_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk_i = ~clk_i;

   psv_supervisor #(
      .BASE_CYCLES (BASE),
      .EXT_SHIFT   (SHIFT),
      .SYNC_STAGES (SYNC)
   ) dut (
      .clk_i       (clk_i),
      .arst_ni     (arst_ni),
      .rise_ok_i   (rise_ok_i),
      .fall_ok_i   (fall_ok_i),
      .ext_div_i   (ext_div_i),
      .pwr_cmd_i   (pwr_cmd_i),
      .por_o       (por_o),
      .deact_req_o (deact_req_o),
      .stat_n_o    (stat_n_o)
   );

   // Behavioural reference: input history queue plus a phase number
   logic [3:0] hist[$];
   int  m_phase;   // 0 waiting, 1 stretching, 2 running, 3 dropping
   int  m_left;
   bit  m_stat;

   always @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         hist.delete();
         m_phase = 0;
         m_left  = 0;
         m_stat  = 1'b0;
      end else begin
         logic [3:0] seen;
         hist.push_back({pwr_cmd_i, ext_div_i, fall_ok_i, rise_ok_i});
         if (hist.size() > SYNC + 1) void'(hist.pop_front());
         seen = (hist.size() == SYNC + 1) ? hist[0] : 4'b0000;
         case (m_phase)
            0: if (seen[0]) begin
                  m_phase = 1;
                  m_left  = seen[2] ? (BASE << SHIFT) : BASE;
               end
            1: if (!seen[0]) m_phase = 0;
               else begin
                  m_left--;
                  if (m_left == 0) m_phase = 2;
               end
            2: if (!seen[1]) begin
                  m_phase = 3;
                  m_stat  = 1'b0;
               end else if (seen[3]) m_stat = 1'b1;
            default: m_phase = 0;
         endcase
      end
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_int(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Model comparison on every falling edge
   always @(negedge clk_i) begin
      if (arst_ni && !done) begin
         check("R2/R3/R4/R5", "por_o model", por_o, (m_phase == 0) || (m_phase == 1));
         check("R6", "deact_req_o model", deact_req_o, m_phase == 3);
         check("R7/R8", "stat_n_o model", stat_n_o, m_stat);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_i);
   endtask

   task automatic count_por(output int n);
      n = 0;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk_i);
         if (por_o) n++;
         else break;
      end
   endtask

   task automatic count_deact(input int win, output int n);
      n = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk_i);
         if (deact_req_o) n++;
      end
   endtask

   initial begin
      int n;
      idle(3);
      // R1: reset values while held and right after release
      check("R1", "por_o in reset", por_o, 1'b1);
      check("R1", "deact_req_o in reset", deact_req_o, 1'b0);
      check("R1", "stat_n_o in reset", stat_n_o, 1'b0);
      arst_ni = 1'b1;
      idle(1);
      check("R1", "por_o after release", por_o, 1'b1);
      check("R1", "stat_n_o after release", stat_n_o, 1'b0);

      // R2 / R7: commands ignored while supply is low
      pwr_cmd_i = 1'b1;
      ext_div_i = 1'b1;
      idle(30);
      check("R2", "por_o held with supply low", por_o, 1'b1);
      check("R7", "stat_n_o ignores command in reset", stat_n_o, 1'b0);
      pwr_cmd_i = 1'b0;
      ext_div_i = 1'b0;
      idle(4);

      // R3: base stretch length
      fall_ok_i = 1'b1;
      rise_ok_i = 1'b1;
      count_por(n);
      check_int("R3", "base stretch cycles", n, SYNC + BASE);
      idle(5);
      check("R7", "stat_n_o low before command", stat_n_o, 1'b0);
      pwr_cmd_i = 1'b1;
      idle(SYNC + 2);
      check("R7", "stat_n_o high after command", stat_n_o, 1'b1);
      pwr_cmd_i = 1'b0;
      idle(3);

      // R6 / R8: dropout
      rise_ok_i = 1'b0;
      fall_ok_i = 1'b0;
      count_deact(10, n);
      check_int("R6", "deact pulses on dropout", n, 1);
      check("R8", "stat_n_o low after dropout", stat_n_o, 1'b0);
      check("R6", "por_o back after dropout", por_o, 1'b1);

      // R4: extended stretch, ext flag drops mid-stretch
      ext_div_i = 1'b1;
      fall_ok_i = 1'b1;
      rise_ok_i = 1'b1;
      fork
         count_por(n);
         begin idle(8); ext_div_i = 1'b0; end
      join
      check_int("R4", "extended stretch cycles", n, SYNC + (BASE << SHIFT));
      idle(6);
      check("R8", "stat_n_o still low after re-power", stat_n_o, 1'b0);
      pwr_cmd_i = 1'b1;
      idle(SYNC + 2);
      check("R8", "stat_n_o high after new command", stat_n_o, 1'b1);

      // R6: dropout with command held high
      rise_ok_i = 1'b0;
      idle(3);
      check("R6", "rise loss alone keeps block active", por_o, 1'b0);
      fall_ok_i = 1'b0;
      count_deact(8, n);
      check_int("R6", "deact pulses second dropout", n, 1);
      check("R8", "stat_n_o low with command held", stat_n_o, 1'b0);
      pwr_cmd_i = 1'b0;
      idle(3);

      // R5: rise drops mid-stretch, then restarts
      fall_ok_i = 1'b1;
      rise_ok_i = 1'b1;
      idle(SYNC + 10);
      rise_ok_i = 1'b0;
      idle(4);
      check("R5", "por_o held after rise loss", por_o, 1'b1);
      check_int("R5", "no deact on rise loss in stretch", int'(deact_req_o), 0);
      rise_ok_i = 1'b1;
      count_por(n);
      check_int("R5", "restarted stretch cycles", n, SYNC + BASE);
      idle(5);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule